// File: doc/BRIEF.md
# Fixed Off-Time Mixed-Decay Current Regulator

This block regulates the current in one motor phase, cycle by cycle, from a master oscillator clock. It drives the diagonal transistor pair of one full bridge until an external comparator reports that the winding current has reached its trip level. It then holds the bridge off for a fixed number of clock cycles and starts the next on-phase. During the first cycles of each on-phase the comparator flag is masked (blanking), so switching transients cannot end the on-phase early.

The off-time can be spent in two ways. Slow decay switches off only the source device. Fast decay switches off both devices of the conducting pair. When the step logic requests mixed decay, the off-time begins with a selectable number of fast-decay cycles and finishes in slow decay. The fraction is captured at the trip that starts each off-time.

A disable input or a fault input forces every device off without stopping the internal timing. A zero-magnitude reference holds the bridge in slow decay and suppresses drive.

The states are:
- `ST_BLANK`: on-phase with the comparator masked.
- `ST_DRIVE`: on-phase waiting for trip.
- `ST_FAST`: off-time, fast part.
- `ST_SLOW`: off-time, slow part.
- `ST_HOLD`: zero reference.

The transitions are:
- BLANK→DRIVE when blanking expires.
- BLANK→FAST/SLOW when blanking expires with trip already high.
- DRIVE→FAST/SLOW on trip.
- FAST→SLOW when the fast count is used up.
- FAST/SLOW→BLANK when the off-time expires.
- any→HOLD while the zero reference is high.
- HOLD→BLANK when it drops.

Top module: `pwm_decay_reg`

## Requirements
- R1: After reset the block is in a blanking on-phase. The output is drive (`bridge_o` = 2'b01) for exactly 6 cycles, even with trip high.
- R2: After blanking the output stays at drive until `trip_i` is sampled high. The off-time begins on the next clock.
- R3: Every off-time lasts exactly 87 cycles: fast cycles plus slow cycles.
- R4: After each off-time the output is drive for 6 cycles, during which `trip_i` is ignored.
- R5: If `trip_i` is high when blanking ends, the off-time starts immediately, with no further drive cycle.
- R6: With `mixed_req_i` low, the whole off-time is slow decay (`bridge_o` = 2'b10), whatever the value of `fast_sel_i`.
- R7: With `mixed_req_i` high, the fast-decay portion (`bridge_o` = 2'b11) comes first and has the following length, selected by `fast_sel_i`. Slow decay follows for the rest of the off-time.
  - 2'b00 selects 0 cycles.
  - 2'b01 selects 10 cycles.
  - 2'b10 selects 23 cycles.
  - 2'b11 selects all 87 cycles.
- R8: `mixed_req_i` and `fast_sel_i` are sampled at the trip. Changes during the off-time do not alter that off-time's split.
- R9: While `disable_i` is high, `bridge_o` is all-off (2'b00) and the off-time timer keeps counting.
- R10: While `fault_i` is high, `bridge_o` is all-off and the off-time timer keeps counting.
- R11: One cycle after `zero_ref_i` rises, the output is slow decay, held with no drive whatever `trip_i` does. When it falls, a blanking on-phase of 6 cycles follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | master oscillator clock |
| rst_n | input | 1 | asynchronous active-low reset |
| trip_i | input | 1 | comparator flag, current at trip level |
| mixed_req_i | input | 1 | step logic requests mixed decay (current falling) |
| fast_sel_i | input | 2 | fast-decay fraction select |
| zero_ref_i | input | 1 | reference magnitude is zero |
| disable_i | input | 1 | high forces all devices off |
| fault_i | input | 1 | thermal or undervoltage fault, forces all off |
| bridge_o | output | 2 | 00 off, 01 drive, 10 slow decay, 11 fast decay |

## Verification
The off-time split is tried with five decay settings:
- Slow-only request with the full-fast code present, which shows that the request gates the fraction.
- Each of the four mixed fractions, whose measured fast and slow run lengths separate every code and confirm the 87-cycle total.

A trip held high across blanking separates masking from the immediate off-time entry. Changing the fraction right after a trip shows that it is captured. Disable and fault windows placed inside an off-time show, through the shortened visible remainder, that timing continued behind the forced-off output. The zero-reference hold is exercised with trip toggling, and its release is timed.

// File: rtl/pwm_decay_pkg.sv
package pwm_decay_pkg;

    typedef enum logic [1:0] {
        BR_OFF   = 2'b00,
        BR_DRIVE = 2'b01,
        BR_SLOW  = 2'b10,
        BR_FAST  = 2'b11
    } bridge_cmd_t;

    typedef enum logic [2:0] {
        ST_BLANK,
        ST_DRIVE,
        ST_FAST,
        ST_SLOW,
        ST_HOLD
    } reg_state_t;

endpackage

// File: rtl/pdr_cycle_timer.sv
module pdr_cycle_timer #(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] TOP = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (cnt != TOP)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/pdr_fast_split.sv
module pdr_fast_split #(
    parameter int CW       = 7,
    parameter int OFF_CYC  = 87,
    parameter int FAST_LO  = 10,
    parameter int FAST_MID = 23
) (
    input  logic          mixed,
    input  logic [1:0]    sel,
    output logic [CW-1:0] fast_cyc
);
    always_comb begin
        if (!mixed) begin
            fast_cyc = '0;
        end else begin
            unique case (sel)
                2'b00:   fast_cyc = '0;
                2'b01:   fast_cyc = CW'(FAST_LO);
                2'b10:   fast_cyc = CW'(FAST_MID);
                default: fast_cyc = CW'(OFF_CYC);
            endcase
        end
    end
endmodule

// File: rtl/pwm_decay_reg.sv
module pwm_decay_reg #(
    parameter int OFF_CYC   = 87,
    parameter int BLANK_CYC = 6,
    parameter int FAST_LO   = 10,
    parameter int FAST_MID  = 23
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trip_i,
    input  logic       mixed_req_i,
    input  logic [1:0] fast_sel_i,
    input  logic       zero_ref_i,
    input  logic       disable_i,
    input  logic       fault_i,
    output logic [1:0] bridge_o
);
    import pwm_decay_pkg::*;

    localparam int MAXC = (OFF_CYC > BLANK_CYC) ? OFF_CYC : BLANK_CYC;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] OFF_LAST   = CW'(OFF_CYC - 1);
    localparam logic [CW-1:0] BLANK_LAST = CW'(BLANK_CYC - 1);

    reg_state_t    state_q, state_d;
    logic [CW-1:0] tmr;
    logic          tmr_clr;
    logic [CW-1:0] fast_now, fast_q;
    reg_state_t    off_entry;
    logic          in_off_q, in_off_d;

    pdr_fast_split #(
        .CW(CW), .OFF_CYC(OFF_CYC), .FAST_LO(FAST_LO), .FAST_MID(FAST_MID)
    ) u_split (
        .mixed    (mixed_req_i),
        .sel      (fast_sel_i),
        .fast_cyc (fast_now)
    );

    pdr_cycle_timer #(.CW(CW)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .cnt   (tmr)
    );

    assign off_entry = (fast_now == '0) ? ST_SLOW : ST_FAST;
    assign in_off_q  = (state_q == ST_FAST) || (state_q == ST_SLOW);
    assign in_off_d  = (state_d == ST_FAST) || (state_d == ST_SLOW);
    // the off-time counter runs across the fast-to-slow handover
    assign tmr_clr   = (state_d != state_q) && !(in_off_q && in_off_d);

    always_comb begin
        state_d = state_q;
        if (zero_ref_i) begin
            state_d = ST_HOLD;
        end else begin
            unique case (state_q)
                ST_HOLD:  state_d = ST_BLANK;
                ST_BLANK: if (tmr == BLANK_LAST)
                              state_d = trip_i ? off_entry : ST_DRIVE;
                ST_DRIVE: if (trip_i) state_d = off_entry;
                ST_FAST:  if (tmr == OFF_LAST)          state_d = ST_BLANK;
                          else if (tmr == fast_q - 1'b1) state_d = ST_SLOW;
                ST_SLOW:  if (tmr == OFF_LAST)          state_d = ST_BLANK;
                default:  state_d = ST_BLANK;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_BLANK;
            fast_q  <= '0;
        end else begin
            state_q <= state_d;
            if (in_off_d && !in_off_q)
                fast_q <= fast_now;
        end
    end

    always_comb begin
        if (disable_i || fault_i) begin
            bridge_o = BR_OFF;
        end else begin
            unique case (state_q)
                ST_BLANK, ST_DRIVE: bridge_o = BR_DRIVE;
                ST_FAST:            bridge_o = BR_FAST;
                default:            bridge_o = BR_SLOW;
            endcase
        end
    end

    // R2: a trip during the unmasked on-phase ends it on the next clock
    assert_trip_ends_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRIVE && trip_i && !zero_ref_i) |=> (state_q == ST_FAST || state_q == ST_SLOW))
        else $error("assert_trip_ends_drive_R2");

    // R4: trip is masked before blanking has run its course
    assert_blank_masks_trip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BLANK && tmr < BLANK_LAST && !zero_ref_i) |=> state_q == ST_BLANK)
        else $error("assert_blank_masks_trip_R4");

    // R7: fast decay never resumes once slow decay has started
    assert_fast_before_slow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLOW && !zero_ref_i) |=> state_q != ST_FAST)
        else $error("assert_fast_before_slow_R7");

    // R3: off-time ends into blanking at its last counted cycle
    assert_off_expires_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_off_q && tmr == OFF_LAST && !zero_ref_i) |=> state_q == ST_BLANK)
        else $error("assert_off_expires_R3");

    // R11: zero reference forces the hold state
    assert_zero_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        zero_ref_i |=> (state_q == ST_HOLD && bridge_o != BR_DRIVE))
        else $error("assert_zero_hold_R11");

    // R9/R10: disable or fault leaves every device off
    assert_forced_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (disable_i || fault_i) |-> bridge_o == BR_OFF)
        else $error("assert_forced_off_R9");
endmodule

// File: tb/sim_pwm_decay_reg.sv
module sim_pwm_decay_reg;
    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] OFF = 2'b00, DRV = 2'b01, SLW = 2'b10, FST = 2'b11;

    // mixed, sel, expected fast, expected slow
    localparam int NVEC = 5;
    localparam int VEC [NVEC][4] = '{
        '{0, 3, 0, 87},
        '{1, 0, 0, 87},
        '{1, 1, 10, 77},
        '{1, 2, 23, 64},
        '{1, 3, 87, 0}
    };

    logic clk = 0, rst_n = 0, trip = 0, mixed = 0, zero = 0, dis = 0, flt = 0;
    logic [1:0] sel = 0;
    logic [1:0] bridge;
    int checks = 0, fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_decay_reg u0 (
        .clk(clk), .rst_n(rst_n), .trip_i(trip), .mixed_req_i(mixed),
        .fast_sel_i(sel), .zero_ref_i(zero), .disable_i(dis), .fault_i(flt),
        .bridge_o(bridge)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic run_len(input logic [1:0] v, output int n);
        n = 0;
        while (bridge == v && n < 500) begin
            n++;
            step();
        end
    endtask

    task automatic settle_drive();
        trip = 0;
        while (bridge != DRV) step();
        repeat (8) step();
    endtask

    task automatic fire_trip();
        @(negedge clk);
        trip = 1;
        @(negedge clk);
        trip = 0;
        #1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int n, f, s, bad;
        trip = 1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R1: blanking drive after reset, trip masked
        check("R1 reset drive code", bridge, DRV);
        run_len(DRV, n);
        check("R1 blanking length after reset", n, 6);
        // R5: trip high at end of blanking -> off-time at once
        check("R5 immediate off after blanking", int'(bridge == SLW || bridge == FST), 1);
        trip = 0;

        // vector table: R3 R6 R7
        for (int i = 0; i < NVEC; i++) begin
            settle_drive();
            mixed = VEC[i][0][0];
            sel   = VEC[i][1][1:0];
            check("R2 drive held before trip", bridge, DRV);
            fire_trip();
            run_len(FST, f);
            run_len(SLW, s);
            check(VEC[i][0] == 0 ? "R6 fast length" : "R7 fast length", f, VEC[i][2]);
            check("R7 slow length", s, VEC[i][3]);
            check("R3 off-time total", f + s, 87);
        end

        // R4 and R5: trip held through off-time end
        settle_drive();
        mixed = 0;
        @(negedge clk);
        trip = 1;
        step();
        run_len(SLW, s);
        check("R3 off-time with trip held", s, 87);
        run_len(DRV, n);
        check("R4 blanking ignores trip", n, 6);
        check("R5 off after blanking", bridge, SLW);
        trip = 0;

        // R8: fraction captured at trip
        settle_drive();
        mixed = 1;
        sel = 2'b01;
        @(negedge clk);
        trip = 1;
        @(negedge clk);
        trip = 0;
        sel = 2'b11;
        mixed = 0;
        #1;
        run_len(FST, f);
        run_len(SLW, s);
        check("R8 captured fast length", f, 10);
        check("R8 captured slow length", s, 77);

        // R9: disable inside off-time, timing continues
        settle_drive();
        mixed = 1;
        sel = 2'b10;
        @(negedge clk);
        trip = 1;
        @(negedge clk);
        trip = 0;
        dis = 1;
        #1;
        bad = 0;
        for (int k = 0; k < 30; k++) begin
            if (bridge != OFF) bad++;
            if (k < 29) step();
        end
        check("R9 outputs off while disabled", bad, 0);
        @(negedge clk);
        dis = 0;
        #1;
        run_len(SLW, s);
        check("R9 remaining slow after disable", s, 57);

        // R10: fault inside fast portion
        settle_drive();
        sel = 2'b01;
        @(negedge clk);
        trip = 1;
        @(negedge clk);
        trip = 0;
        flt = 1;
        #1;
        bad = 0;
        for (int k = 0; k < 5; k++) begin
            if (bridge != OFF) bad++;
            if (k < 4) step();
        end
        check("R10 outputs off during fault", bad, 0);
        @(negedge clk);
        flt = 0;
        #1;
        run_len(FST, f);
        run_len(SLW, s);
        check("R10 remaining fast after fault", f, 5);
        check("R10 remaining slow after fault", s, 77);

        // R11: zero reference hold
        settle_drive();
        @(negedge clk);
        zero = 1;
        step();
        bad = 0;
        for (int k = 0; k < 20; k++) begin
            trip = k[0];
            if (bridge != SLW) bad++;
            step();
        end
        check("R11 slow hold, no drive", bad, 0);
        @(negedge clk);
        zero = 0;
        trip = 1;
        #1;
        check("R11 still held at release", bridge, SLW);
        step();
        run_len(DRV, n);
        check("R11 blanking after release", n, 6);
        trip = 0;

        done = 1;
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule